// File: doc/BRIEF.md
# Sequence-Triggered Multiply/Divide Unit

This block is an unsigned arithmetic engine that sits on a simple byte-wide register bus. Software loads operands into six byte registers, R0 to R5, one byte per bus write, low byte before high byte. Nothing else names the operation: the order of the writes selects it. The bus write to R5 that completes a valid order starts the calculation.

Three orders are valid:

- R0, R1, R2, R3, R4, R5 selects a 32-by-16 divide. The dividend is in R0..R3 and the divisor in R4/R5.
- R0, R1, R4, R5 selects a 16-by-16 divide. The dividend is in R0/R1 and the divisor in R4/R5.
- R0, R4, R1, R5 selects a 16-by-16 multiply. The factors are in R0/R1 and R4/R5.

A fixed latency applies to each operation: 17, 9 or 11 clocks. The unit computes two result bits per clock in an iterative datapath. When it finishes, it writes the results back into the same byte registers and raises a done flag. It also keeps a sticky error flag. That flag catches a data-register access made while the unit is busy, and a divide by zero.

Top module: `seqArithTop`

## Requirements
- R1: After reset, all six data registers read 0x00. The status register reads 0x00.
- R2: Writes to addresses 0,1,2,3,4,5 in that order start a 32/16 unsigned divide. Afterwards R0..R3 hold the quotient (R0 lowest byte) and R4/R5 hold the 16-bit remainder (R4 low byte).
- R3: Writes to addresses 0,1,4,5 in that order start a 16/16 unsigned divide. Neither R2 nor R3 may be written in between. Afterwards R0/R1 hold the quotient and R4/R5 the remainder, each with the low byte first.
- R4: Writes to addresses 0,4,1,5 in that order start a 16x16 unsigned multiply. Afterwards R0..R3 hold the 32-bit product (R0 lowest byte), and R4/R5 keep the bytes that were written to them.
- R5: A write to R5 starts nothing unless the data-register writes before it form one of the three orders. A data write that breaks the order clears the tracking. If that breaking write is to R0, it counts as the first write of a new order.
- R6: Bus reads, and writes to addresses 6 and 7, may fall between the writes of an order without breaking it. Writes to addresses 6 and 7 change nothing.
- R7: The busy bit goes high on the clock edge that takes the starting R5 write. It stays high for exactly 17 clocks for the 32/16 divide, 9 for the 16/16 divide and 11 for the multiply. The results and the done bit appear on the same edge where busy falls, and busy and done are never both set.
- R8: A divide with a zero divisor returns an all-ones quotient and sets the error bit. The remainder is the low 16 bits of the dividend.
- R9: A data-register read or write while busy is high sets the error bit. Such a write does not change the register. The error bit stays set until the next accepted start clears it; that start also clears done.
- R10: Address 6 is the status register. It reads bit0 = busy, bit1 = done and bit2 = error; the other bits are 0. Addresses 0..5 are R0..R5. rdData is 0x00 when rdRq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address: 0..5 data, 6 status |
| wrData | input | 8 | Byte to write |
| wrRq | input | 1 | Write strobe, taken on the rising edge |
| rdRq | input | 1 | Read strobe |
| rdData | output | 8 | Read data, a combinational function of addr while rdRq is high |

## Verification
A sequence tracker left in the wrong state would show up at the status register on the first bus cycle after the R5 write. Either busy would fail to rise after a valid order, or it would rise after an invalid one.

A step count or latency count that is off shows directly as a busy window of the wrong length. It also shows in the first result bytes read back, because the quotient or product would be shifted by one step.

An error flag that is not sticky, or that is cleared at the wrong time, is visible in the status byte. It can be seen once the operation ends and again when the next operation starts.

// File: rtl/seqArithPkg.sv
package seqArithPkg;
  localparam int BYTE_W        = 8;
  localparam int NUM_DATA      = 6;
  localparam int ADDR_W        = 3;
  localparam int STAT_ADDR     = 6;
  localparam int HALF_W        = 2 * BYTE_W;
  localparam int FULL_W        = 4 * BYTE_W;
  localparam int BITS_PER_STEP = 2;
  localparam int STEPS_LONG    = FULL_W / BITS_PER_STEP;
  localparam int STEPS_SHORT   = HALF_W / BITS_PER_STEP;

  typedef enum logic [1:0] {OP_NONE, OP_DIV32, OP_DIV16, OP_MUL} opKind_t;

  typedef struct packed {
    logic    busWr;
    logic    load;
    opKind_t op;
    logic    step;
    logic    finish;
  } ctrlStrobe_t;
endpackage

// File: rtl/seqArithCtrl.sv
module seqArithCtrl
  import seqArithPkg::*;
#(
  parameter int LAT_DIV32 = 17,
  parameter int LAT_DIV16 = 9,
  parameter int LAT_MUL   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrRq,
  input  logic              rdRq,
  input  logic              divZero,
  output ctrlStrobe_t       strobe,
  output logic              busy,
  output logic              done,
  output logic              errFlag
);
  localparam int LAT_A   = (LAT_DIV32 > LAT_DIV16) ? LAT_DIV32 : LAT_DIV16;
  localparam int LAT_MAX = (LAT_A > LAT_MUL) ? LAT_A : LAT_MUL;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  typedef enum logic [3:0] {
    T_IDLE, T_0, T_01, T_012, T_0123, T_01234, T_014, T_04, T_041
  } trk_t;

  trk_t           trk, trkNext;
  opKind_t        opNext, opReg;
  logic [CNT_W-1:0] cnt, stepFloor;
  logic           dataAddr, dataWr, accessBusy, start;

  function automatic logic [CNT_W-1:0] latOf(opKind_t o);
    case (o)
      OP_DIV32: return CNT_W'(LAT_DIV32);
      OP_DIV16: return CNT_W'(LAT_DIV16);
      default:  return CNT_W'(LAT_MUL);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] stepsOf(opKind_t o);
    return (o == OP_DIV32) ? CNT_W'(STEPS_LONG) : CNT_W'(STEPS_SHORT);
  endfunction

  assign dataAddr   = (addr < ADDR_W'(NUM_DATA));
  assign dataWr     = wrRq && dataAddr;
  assign accessBusy = busy && (wrRq || rdRq) && dataAddr;

  // Order tracker: a mismatching write drops back, a write to R0 always re-arms.
  always_comb begin
    trkNext = trk;
    opNext  = OP_NONE;
    if (dataWr && !busy) begin
      trkNext = (addr == ADDR_W'(0)) ? T_0 : T_IDLE;
      case (trk)
        T_0:     if (addr == ADDR_W'(1)) trkNext = T_01;
                 else if (addr == ADDR_W'(4)) trkNext = T_04;
        T_01:    if (addr == ADDR_W'(2)) trkNext = T_012;
                 else if (addr == ADDR_W'(4)) trkNext = T_014;
        T_012:   if (addr == ADDR_W'(3)) trkNext = T_0123;
        T_0123:  if (addr == ADDR_W'(4)) trkNext = T_01234;
        T_01234: if (addr == ADDR_W'(5)) opNext = OP_DIV32;
        T_014:   if (addr == ADDR_W'(5)) opNext = OP_DIV16;
        T_04:    if (addr == ADDR_W'(1)) trkNext = T_041;
        T_041:   if (addr == ADDR_W'(5)) opNext = OP_MUL;
        default: ;
      endcase
      if (opNext != OP_NONE) trkNext = T_IDLE;
    end
  end

  assign start = (opNext != OP_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trk       <= T_IDLE;
      opReg     <= OP_NONE;
      busy      <= 1'b0;
      done      <= 1'b0;
      errFlag   <= 1'b0;
      cnt       <= '0;
      stepFloor <= '0;
    end else begin
      trk <= trkNext;
      if (start) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        errFlag   <= 1'b0;
        opReg     <= opNext;
        cnt       <= latOf(opNext) - CNT_W'(1);
        stepFloor <= latOf(opNext) - stepsOf(opNext);
      end else if (busy) begin
        if (cnt == '0) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          errFlag <= errFlag | divZero | accessBusy;
        end else begin
          cnt     <= cnt - CNT_W'(1);
          errFlag <= errFlag | accessBusy;
        end
      end
    end
  end

  assign strobe.busWr  = dataWr && !busy;
  assign strobe.load   = start;
  assign strobe.op     = start ? opNext : opReg;
  assign strobe.step   = busy && (cnt >= stepFloor);
  assign strobe.finish = busy && (cnt == '0);
endmodule

// File: rtl/seqArithPath.sv
module seqArithPath
  import seqArithPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] dataOut,
  output logic              divZero
);
  logic [BYTE_W-1:0] regs [NUM_DATA];
  logic [FULL_W-1:0] work, workNext;
  logic [HALF_W:0]   rem, remNext;
  logic [HALF_W-1:0] opB, newHigh;

  assign newHigh = {wrData, regs[4]};

  // One step: BITS_PER_STEP restoring-divide or shift-add iterations.
  always_comb begin
    workNext = work;
    remNext  = rem;
    for (int i = 0; i < BITS_PER_STEP; i++) begin
      if (strobe.op == OP_MUL) begin
        workNext = {workNext[FULL_W-2:0], 1'b0} +
                   (remNext[HALF_W-1] ? {{HALF_W{1'b0}}, opB} : '0);
        remNext  = {remNext[HALF_W-1:0], 1'b0};
      end else begin
        remNext  = {remNext[HALF_W-1:0], workNext[FULL_W-1]};
        workNext = {workNext[FULL_W-2:0], 1'b0};
        if (remNext >= {1'b0, opB}) begin
          remNext     = remNext - {1'b0, opB};
          workNext[0] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DATA; i++) regs[i] <= '0;
      work    <= '0;
      rem     <= '0;
      opB     <= '0;
      divZero <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_DATA; i++)
        if (strobe.busWr && addr == ADDR_W'(i)) regs[i] <= wrData;
      if (strobe.load) begin
        divZero <= (strobe.op != OP_MUL) && (newHigh == '0);
        case (strobe.op)
          OP_DIV32: begin
            work <= {regs[3], regs[2], regs[1], regs[0]};
            rem  <= '0;
            opB  <= newHigh;
          end
          OP_DIV16: begin
            work <= {regs[1], regs[0], {HALF_W{1'b0}}};
            rem  <= '0;
            opB  <= newHigh;
          end
          default: begin
            work <= '0;
            rem  <= {1'b0, newHigh};
            opB  <= {regs[1], regs[0]};
          end
        endcase
      end else if (strobe.step) begin
        work <= workNext;
        rem  <= remNext;
      end else if (strobe.finish) begin
        regs[0] <= work[BYTE_W-1:0];
        regs[1] <= work[2*BYTE_W-1:BYTE_W];
        if (strobe.op != OP_DIV16) begin
          regs[2] <= work[3*BYTE_W-1:2*BYTE_W];
          regs[3] <= work[4*BYTE_W-1:3*BYTE_W];
        end
        if (strobe.op != OP_MUL) begin
          regs[4] <= rem[BYTE_W-1:0];
          regs[5] <= rem[2*BYTE_W-1:BYTE_W];
        end
      end
    end
  end

  always_comb begin
    dataOut = '0;
    for (int i = 0; i < NUM_DATA; i++)
      if (addr == ADDR_W'(i)) dataOut = regs[i];
  end
endmodule

// File: rtl/seqArithTop.sv
module seqArithTop
  import seqArithPkg::*;
#(
  parameter int LAT_DIV32 = 17,
  parameter int LAT_DIV16 = 9,
  parameter int LAT_MUL   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrRq,
  input  logic              rdRq,
  output logic [BYTE_W-1:0] rdData
);
  ctrlStrobe_t       strobe;
  logic              busy, done, errFlag, divZero;
  logic [BYTE_W-1:0] dataOut;

  seqArithCtrl #(
    .LAT_DIV32(LAT_DIV32), .LAT_DIV16(LAT_DIV16), .LAT_MUL(LAT_MUL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrRq(wrRq), .rdRq(rdRq),
    .divZero(divZero), .strobe(strobe), .busy(busy), .done(done), .errFlag(errFlag)
  );

  seqArithPath i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .dataOut(dataOut), .divZero(divZero)
  );

  always_comb begin
    if (!rdRq)                            rdData = '0;
    else if (addr == ADDR_W'(STAT_ADDR))  rdData = {{(BYTE_W-3){1'b0}}, errFlag, done, busy};
    else                                  rdData = dataOut;
  end
endmodule

// File: rtl/seqArithChecker.sv
module seqArithChecker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] addr,
  input logic       wrRq,
  input logic       rdRq,
  input logic       busy,
  input logic       done,
  input logic       errFlag
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R7

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R7

  AST_START_ON_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrRq && addr == 3'd5)); // R5

  AST_ACCESS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (wrRq || rdRq) && addr < 3'd6) |=> errFlag); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(wrRq && addr == 3'd5)) |=> errFlag); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!errFlag && !done)); // R9
endmodule

bind seqArithTop seqArithChecker i_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrRq(wrRq), .rdRq(rdRq),
  .busy(busy), .done(done), .errFlag(errFlag)
);

// File: tb/test_seqArithTop.sv
`timescale 1ns/1ps
module test_seqArithTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrRq = 1'b0;
  logic       rdRq = 1'b0;
  logic [7:0] rdData;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seqArithTop i_seqArithTop (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrRq(wrRq), .rdRq(rdRq), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrRq = 1'b1; rdRq = 1'b0;
    @(negedge clk); wrRq = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rdRq = 1'b1; wrRq = 1'b0;
    #1 v = rdData;
    @(negedge clk); rdRq = 1'b0;
  endtask

  // Called at the negedge right after the starting write edge.
  task automatic waitDone(output int cycles, output logic [7:0] stat);
    addr = 3'd6; rdRq = 1'b1; cycles = 0;
    #1;
    while (rdData[0] && cycles < 200) begin
      cycles++;
      @(negedge clk); #1;
    end
    stat = rdData;
    rdRq = 1'b0;
  endtask

  task automatic read32(output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    busRead(3'd0, b0); busRead(3'd1, b1); busRead(3'd2, b2); busRead(3'd3, b3);
    v = {b3, b2, b1, b0};
  endtask

  task automatic read16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] b0, b1;
    busRead(lo, b0); busRead(lo + 3'd1, b1);
    v = {b1, b0};
  endtask

  task automatic runDiv32(input logic [31:0] n, input logic [15:0] d);
    int c; logic [7:0] s; logic [31:0] q, qe; logic [15:0] r, re;
    string tag;
    tag = (d == 0) ? "R8" : "R2";
    qe = (d == 0) ? 32'hFFFF_FFFF : n / {16'h0, d};
    re = (d == 0) ? n[15:0] : 16'(n % {16'h0, d});
    busWrite(3'd0, n[7:0]); busWrite(3'd1, n[15:8]);
    busWrite(3'd2, n[23:16]); busWrite(3'd3, n[31:24]);
    busWrite(3'd4, d[7:0]); busWrite(3'd5, d[15:8]);
    waitDone(c, s);
    chk(c == 17, "R7 div32 latency", c, 17);
    chk(s == {5'b0, (d == 0), 2'b10}, "R10 div32 status", s, {5'b0, (d == 0), 2'b10});
    read32(q); read16(3'd4, r);
    chk(q == qe, {tag, " div32 quotient"}, q, qe);
    chk(r == re, {tag, " div32 remainder"}, r, re);
  endtask

  task automatic runDiv16(input logic [15:0] n, input logic [15:0] d);
    int c; logic [7:0] s; logic [15:0] q, qe, r, re;
    string tag;
    tag = (d == 0) ? "R8" : "R3";
    qe = (d == 0) ? 16'hFFFF : n / d;
    re = (d == 0) ? n : n % d;
    busWrite(3'd0, n[7:0]); busWrite(3'd1, n[15:8]);
    busWrite(3'd4, d[7:0]); busWrite(3'd5, d[15:8]);
    waitDone(c, s);
    chk(c == 9, "R7 div16 latency", c, 9);
    chk(s == {5'b0, (d == 0), 2'b10}, {tag, " div16 status"}, s, {5'b0, (d == 0), 2'b10});
    read16(3'd0, q); read16(3'd4, r);
    chk(q == qe, {tag, " div16 quotient"}, q, qe);
    chk(r == re, {tag, " div16 remainder"}, r, re);
  endtask

  task automatic runMul(input logic [15:0] a, input logic [15:0] b);
    int c; logic [7:0] s; logic [31:0] p, pe; logic [15:0] hb;
    pe = {16'h0, a} * {16'h0, b};
    busWrite(3'd0, a[7:0]); busWrite(3'd4, b[7:0]);
    busWrite(3'd1, a[15:8]); busWrite(3'd5, b[15:8]);
    waitDone(c, s);
    chk(c == 11, "R7 mul latency", c, 11);
    chk(s == 8'h02, "R4 mul status", s, 8'h02);
    read32(p); read16(3'd4, hb);
    chk(p == pe, "R4 mul product", p, pe);
    chk(hb == b, "R4 mul R4/R5 kept", hb, b);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    busRead(3'd6, v);
    chk(v == 8'h00, "R1 reset status", v, 0);
    for (int i = 0; i < 6; i++) begin
      busRead(3'(i), v);
      chk(v == 8'h00, "R1 reset data", v, 0);
    end
    @(negedge clk); addr = 3'd6; rdRq = 1'b0; #1;
    chk(rdData == 8'h00, "R10 read idle zero", rdData, 0);
  endtask

  task automatic t_badSeq;
    logic [7:0] v;
    busWrite(3'd0, 8'h10); busWrite(3'd1, 8'h20); busWrite(3'd2, 8'h30); busWrite(3'd5, 8'h01);
    busRead(3'd6, v);
    chk(v[0] == 1'b0, "R5 0,1,2,5 no start", v, 0);
    busWrite(3'd4, 8'h05); busWrite(3'd5, 8'h00);
    busRead(3'd6, v);
    chk(v[0] == 1'b0, "R5 4,5 no start", v, 0);
    busWrite(3'd0, 8'h01); busWrite(3'd1, 8'h02); busWrite(3'd3, 8'h03);
    busWrite(3'd4, 8'h04); busWrite(3'd5, 8'h05);
    busRead(3'd6, v);
    chk(v[0] == 1'b0, "R5 broken order no start", v, 0);
    busWrite(3'd0, 8'h11); busWrite(3'd4, 8'h22);
    runDiv16(16'h0001, 16'h0003); // R5: second R0 write re-arms
  endtask

  task automatic t_interleave;
    int c; logic [7:0] s, v; logic [31:0] p;
    busWrite(3'd0, 8'h34); busRead(3'd6, v);
    busWrite(3'd4, 8'h78); busWrite(3'd6, 8'hFF);
    busRead(3'd2, v); busWrite(3'd1, 8'h12);
    busRead(3'd7, v); busWrite(3'd7, 8'hAA);
    busWrite(3'd5, 8'h56);
    waitDone(c, s);
    chk(c == 11, "R6 interleaved mul latency", c, 11);
    chk(s == 8'h02, "R6 interleaved status", s, 8'h02);
    read32(p);
    chk(p == 32'h1234 * 32'h5678, "R6 interleaved product", p, 32'h1234 * 32'h5678);
  endtask

  task automatic t_busyAccess;
    int c; logic [7:0] s, v; logic [31:0] p;
    busWrite(3'd0, 8'h02); busWrite(3'd4, 8'h04);
    busWrite(3'd1, 8'h01); busWrite(3'd5, 8'h03);
    busWrite(3'd4, 8'hEE);
    busRead(3'd0, v);
    busRead(3'd6, v);
    chk(v[2:0] == 3'b101, "R9 error while busy", v, 8'h05);
    waitDone(c, s);
    chk(s == 8'h06, "R9 sticky error at done", s, 8'h06);
    busRead(3'd4, v);
    chk(v == 8'h04, "R9 busy write ignored", v, 8'h04);
    read32(p);
    chk(p == 32'h0102 * 32'h0304, "R9 product intact", p, 32'h0102 * 32'h0304);
    busRead(3'd6, v);
    chk(v == 8'h06, "R9 error held while idle", v, 8'h06);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    runDiv32(32'h1234_5678, 16'h1234);
    runDiv32(32'hFFFF_FFFF, 16'h0001);
    runDiv32(32'h0000_0005, 16'hFFFF);
    runDiv16(16'hABCD, 16'h0017);
    runMul(16'hFFFF, 16'hFFFF);
    runMul(16'h1234, 16'h5678);
    runDiv16(16'h4321, 16'h0000);
    runDiv32(32'h89AB_CDEF, 16'h0000);
    runDiv16(16'h00FF, 16'h0010); // R9: start clears error
    t_badSeq();
    t_interleave();
    t_busyAccess();
    runMul(16'h00FF, 16'h0101);   // R9: start clears error
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule